// File: doc/BRIEF.md
# Receive Character Buffer with Hardware Flow Control

This block is the buffering stage on the receive side of one asynchronous serial channel. It sits between the character deserializer and the processor's register port. The deserializer reports two things: a strobe when it sees a valid start bit, and a one-cycle valid pulse carrying the assembled character together with its parity-error, framing-error and break flags. The block keeps up to sixteen characters in arrival order. It gives up an entry only when the processor reads the data register. The status outputs are levels that can be looked at any number of times without side effects.

When the store is full, one more character can wait in a holding slot that stands for the receive shift register. That character moves into the store as soon as an entry frees up. A further character that arrives while the slot is occupied replaces the waiting one, and this raises a sticky overrun flag. Error flags are shown in one of two ways, chosen by a mode input. In per-character mode they belong to the oldest stored character. In block mode they are a running OR of the flags of every character written since the last error-clear command.

An optional automatic request-to-send output throttles the far transmitter. Software must raise it once by command. After that, a start bit seen while the store is full drops it, and it comes back once the store has a free entry. Software commands enable, disable and reset the receiver.

Top module: `rx_char_buffer`

## Requirements
- R1: Characters leave in arrival order. The store holds DEPTH (16) characters. `st_rdy` is high whenever at least one character is stored, and `st_full` is high when all DEPTH entries are occupied. Both follow the occupancy in the same cycle.
- R2: Only a cycle with `rd_data_stb` high removes a character. While the strobe is high, `rd_data` shows the oldest character, and the character is removed at the closing clock edge. The status outputs can be observed without any effect on the contents.
- R3: A character that completes while the store is full goes into the holding slot. It is written into the store at the same edge that removes an entry. The occupancy stays at DEPTH and the order is preserved.
- R4: If a start bit is seen while the slot is occupied and no entry frees up in that cycle, `st_ovr` is set at that edge. The character that completes next replaces the held one, which is lost. The stored characters are not changed. `st_ovr` stays set until an error-clear or a receiver reset.
- R5: With `blk_mode` = 1, the outputs `st_perr`, `st_ferr` and `st_brk` are the OR of the flags of every character written into the store since the last `err_rst_cmd`. Reading characters out does not change them. `err_rst_cmd` clears them and `st_ovr`.
- R6: With `blk_mode` = 0, `st_perr`, `st_ferr` and `st_brk` are the flags of the oldest stored character. All three are 0 when the store is empty.
- R7: After power-on reset `rts` is 0. A `rts_set_cmd` pulse makes `rts` 1 at the next edge and arms automatic control.
- R8: With `rts_auto_en` = 1 and control armed, a start bit seen while `st_full` is high makes `rts` 0 at the next edge. `rts` returns to 1 one edge after the occupancy drops below DEPTH.
- R9: While the receiver is disabled, incoming characters are ignored and stored characters can still be read. A disable command throws away a character waiting in the holding slot.
- R10: `rx_rst_cmd` empties the store and the holding slot, and clears `st_ovr`, the block-mode flags and `rts`. It disarms automatic RTS control and leaves the receiver disabled.
- R11: After power-on reset the receiver is disabled until a `rx_en_cmd` pulse. `rx_rst_cmd` takes priority over `rx_dis_cmd`, which takes priority over `rx_en_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | Valid start bit detected (one-cycle strobe) |
| chr_vld | input | 1 | Assembled character valid (one-cycle strobe) |
| chr_data | input | 8 | Character bits, right-aligned for 5 to 8 bit lengths |
| chr_perr | input | 1 | Parity error of this character |
| chr_ferr | input | 1 | Framing error of this character |
| chr_brk | input | 1 | Break received with this character |
| rd_data_stb | input | 1 | Processor read of the data register; removes the oldest character |
| rx_en_cmd | input | 1 | Enable the receiver |
| rx_dis_cmd | input | 1 | Disable the receiver |
| rx_rst_cmd | input | 1 | Reset the receiver |
| err_rst_cmd | input | 1 | Clear the accumulated error flags and overrun |
| blk_mode | input | 1 | 1 = block error accumulation, 0 = per-character flags |
| rts_auto_en | input | 1 | Allow automatic RTS control |
| rts_set_cmd | input | 1 | Raise RTS by command and arm automatic control |
| rd_data | output | 8 | Oldest stored character (0 when empty) |
| st_rdy | output | 1 | At least one character stored |
| st_full | output | 1 | All entries occupied |
| st_perr | output | 1 | Parity error status |
| st_ferr | output | 1 | Framing error status |
| st_brk | output | 1 | Break status |
| st_ovr | output | 1 | Sticky overrun |
| rts | output | 1 | Request-to-send, 1 = asserted |

## Verification
The assertions assume that every command and strobe is a single-cycle pulse. They also assume that `start_det` comes before the matching `chr_vld` and never falls in the same cycle. The bench drives each character as a start-bit cycle followed by a separate character-valid cycle. It never overlaps a processor read with an arriving character, and it issues only one command per cycle. Under those conditions, every fall of `rts` and every rise of `st_ovr` can be traced back to the start bit of the cycle before.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    parameter int unsigned CHAR_W = 8;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t             flg;
        logic [CHAR_W-1:0]     data;
    } rx_char_t;
endpackage

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
    import rxbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     push,
    input  rx_char_t push_item,
    input  logic     pop,
    output rx_char_t head,
    output logic     full,
    output logic     empty
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    rx_char_t mem [DEPTH];
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign head  = mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && !empty && !clr;
        do_push = push && (!full || do_pop) && !clr;
        if (do_push) st_d.wp = nxt_ptr(st_q.wp);
        if (do_pop)  st_d.rp = nxt_ptr(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_item;
    end
endmodule

// File: rtl/rxbuf_rts.sv
module rxbuf_rts (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic auto_en,
    input  logic start_hit,
    input  logic fifo_full,
    output logic rts
);
    typedef struct packed {
        logic rts;
        logic armed;
        logic held_off;
    } rts_st_t;

    rts_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (arm) begin
            st_d.rts      = 1'b1;
            st_d.armed    = 1'b1;
            st_d.held_off = 1'b0;
        end else if (auto_en && st_q.armed && st_q.rts && start_hit && fifo_full) begin
            st_d.rts      = 1'b0;
            st_d.held_off = 1'b1;
        end else if (st_q.held_off && !fifo_full) begin
            st_d.rts      = 1'b1;
            st_d.held_off = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rts = st_q.rts;
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
    import rxbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              chr_vld,
    input  logic [CHAR_W-1:0] chr_data,
    input  logic              chr_perr,
    input  logic              chr_ferr,
    input  logic              chr_brk,
    input  logic              rd_data_stb,
    input  logic              rx_en_cmd,
    input  logic              rx_dis_cmd,
    input  logic              rx_rst_cmd,
    input  logic              err_rst_cmd,
    input  logic              blk_mode,
    input  logic              rts_auto_en,
    input  logic              rts_set_cmd,
    output logic [CHAR_W-1:0] rd_data,
    output logic              st_rdy,
    output logic              st_full,
    output logic              st_perr,
    output logic              st_ferr,
    output logic              st_brk,
    output logic              st_ovr,
    output logic              rts
);
    typedef struct packed {
        logic      en;
        logic      hold_vld;
        rx_char_t  hold;
        rx_flags_t acc;
        logic      ovr;
    } ctl_st_t;

    ctl_st_t   st_q, st_d;
    logic      pop, room, take, push, ovr_evt;
    rx_char_t  push_item, new_chr, head;
    rx_flags_t shown;
    logic      f_full, f_empty;

    rxbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_rst_cmd),
        .push      (push),
        .push_item (push_item),
        .pop       (pop),
        .head      (head),
        .full      (f_full),
        .empty     (f_empty)
    );

    rxbuf_rts u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_rst_cmd),
        .arm       (rts_set_cmd),
        .auto_en   (rts_auto_en),
        .start_hit (start_det && st_q.en),
        .fifo_full (f_full),
        .rts       (rts)
    );

    always_comb begin
        st_d      = st_q;
        new_chr   = '{flg: '{brk: chr_brk, ferr: chr_ferr, perr: chr_perr}, data: chr_data};
        pop       = rd_data_stb && !f_empty;
        room      = !f_full || pop;
        take      = st_q.en && !rx_dis_cmd && !rx_rst_cmd;
        push      = 1'b0;
        push_item = st_q.hold;
        ovr_evt   = take && start_det && st_q.hold_vld && !room;

        if (take) begin
            if (st_q.hold_vld) begin
                if (room) begin
                    push          = 1'b1;
                    push_item     = st_q.hold;
                    st_d.hold_vld = chr_vld;
                    if (chr_vld) st_d.hold = new_chr;
                end else if (chr_vld) begin
                    st_d.hold = new_chr;
                end
            end else if (chr_vld) begin
                if (room) begin
                    push      = 1'b1;
                    push_item = new_chr;
                end else begin
                    st_d.hold_vld = 1'b1;
                    st_d.hold     = new_chr;
                end
            end
        end

        if (err_rst_cmd) begin
            st_d.acc = '0;
            st_d.ovr = 1'b0;
        end
        if (ovr_evt) st_d.ovr = 1'b1;
        if (push)    st_d.acc = st_d.acc | push_item.flg;

        if (rx_dis_cmd) begin
            st_d.en       = 1'b0;
            st_d.hold_vld = 1'b0;
        end else if (rx_en_cmd) begin
            st_d.en = 1'b1;
        end

        if (rx_rst_cmd) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (blk_mode)     shown = st_q.acc;
        else if (f_empty) shown = '0;
        else              shown = head.flg;
    end

    assign rd_data = f_empty ? '0 : head.data;
    assign st_rdy  = !f_empty;
    assign st_full = f_full;
    assign st_perr = shown.perr;
    assign st_ferr = shown.ferr;
    assign st_brk  = shown.brk;
    assign st_ovr  = st_q.ovr;
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic start_det,
    input logic rd_data_stb,
    input logic rx_rst_cmd,
    input logic err_rst_cmd,
    input logic blk_mode,
    input logic rts_auto_en,
    input logic st_rdy,
    input logic st_full,
    input logic st_perr,
    input logic st_ovr,
    input logic rts
);
    // R2
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rdy && !rd_data_stb && !rx_rst_cmd) |=> st_rdy);

    // R4
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovr) |-> $past(start_det));

    // R4
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovr && !err_rst_cmd && !rx_rst_cmd) |=> st_ovr);

    // R5
    blk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && st_perr && !err_rst_cmd && !rx_rst_cmd) |=> (st_perr || !blk_mode));

    // R8
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> ($past(rx_rst_cmd) || ($past(start_det) && $past(st_full) && $past(rts_auto_en))));

    // R10
    rx_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_cmd |=> (!st_rdy && !rts && !st_ovr));
endmodule

bind rx_char_buffer rxbuf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_det   (start_det),
    .rd_data_stb (rd_data_stb),
    .rx_rst_cmd  (rx_rst_cmd),
    .err_rst_cmd (err_rst_cmd),
    .blk_mode    (blk_mode),
    .rts_auto_en (rts_auto_en),
    .st_rdy      (st_rdy),
    .st_full     (st_full),
    .st_perr     (st_perr),
    .st_ovr      (st_ovr),
    .rts         (rts)
);

// File: tb/tb_rx_char_buffer.sv
module tb_rx_char_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det = 0, chr_vld = 0, chr_perr = 0, chr_ferr = 0, chr_brk = 0;
    logic [7:0] chr_data = '0;
    logic       rd_data_stb = 0, rx_en_cmd = 0, rx_dis_cmd = 0, rx_rst_cmd = 0;
    logic       err_rst_cmd = 0, blk_mode = 0, rts_auto_en = 0, rts_set_cmd = 0;
    logic [7:0] rd_data;
    logic       st_rdy, st_full, st_perr, st_ferr, st_brk, st_ovr, rts;

    int n_chk = 0;
    int n_err = 0;
    logic [10:0] exp_q[$];

    always #5 clk = ~clk;

    rx_char_buffer dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // kind: 0 = expect dropped, 1 = expect stored, 2 = replaces last expected
    task automatic send(input logic [7:0] d, input logic [2:0] f, input int kind);
        tick();
        start_det = 1'b1;
        tick();
        start_det = 1'b0;
        chr_vld = 1'b1;
        chr_data = d;
        {chr_brk, chr_ferr, chr_perr} = f;
        tick();
        chr_vld = 1'b0;
        {chr_brk, chr_ferr, chr_perr} = 3'b000;
        if (kind == 1) exp_q.push_back({f, d});
        else if (kind == 2) begin
            void'(exp_q.pop_back());
            exp_q.push_back({f, d});
        end
    endtask

    task automatic cpu_read();
        tick();
        rd_data_stb = 1'b1;
        tick();
        rd_data_stb = 1'b0;
    endtask

    // monitor: scoreboard comparison of every popped character (R1, R2, R6)
    always @(negedge clk) begin
        if (rst_n && rd_data_stb && st_rdy) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected char", {24'd0, rd_data}, 32'hFFFF);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                chk("R1 data order", {24'd0, rd_data}, {24'd0, e[7:0]});
                if (!blk_mode)
                    chk("R6 head flags", {29'd0, st_brk, st_ferr, st_perr}, {29'd0, e[10:8]});
            end
        end
    end

    initial begin
        #2_000_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R7 rts after reset", rts, 0);
        chk("R1 rdy after reset", st_rdy, 0);
        chk("R1 full after reset", st_full, 0);
        chk("R4 ovr after reset", st_ovr, 0);

        // R11: disabled after power-on reset
        send(8'h11, 3'b000, 0);
        chk("R11 ignored while disabled", st_rdy, 0);
        tick(); rx_en_cmd = 1; tick(); rx_en_cmd = 0;
        rts_auto_en = 1'b1;
        tick(); rts_set_cmd = 1; tick(); rts_set_cmd = 0;
        chk("R7 rts set by command", rts, 1);

        // R1/R6: order and per-character flags
        send(8'hA1, 3'b001, 1);
        send(8'hB2, 3'b010, 1);
        send(8'hC3, 3'b100, 1);
        chk("R6 head flags before read", {st_brk, st_ferr, st_perr}, 3'b001);
        repeat (3) tick();
        chk("R2 status observation keeps data", st_rdy, 1);
        repeat (3) cpu_read();
        chk("R1 empty after reads", st_rdy, 0);
        chk("R6 flags zero when empty", {st_brk, st_ferr, st_perr}, 3'b000);

        // R1/R3/R8: fill, hold one, RTS drop and return
        for (int i = 0; i < 16; i++) send(8'(8'h40 + i), 3'b000, 1);
        chk("R1 full at depth", st_full, 1);
        send(8'h5A, 3'b000, 1);
        chk("R8 rts dropped on start while full", rts, 0);
        chk("R4 no overrun for first held char", st_ovr, 0);
        cpu_read();
        chk("R3 held char refills store", st_full, 1);
        chk("R8 rts still low while full", rts, 0);
        cpu_read();
        tick();
        chk("R8 rts restored after space", rts, 1);
        for (int i = 0; i < 15; i++) cpu_read();
        chk("R3 drained including held char", st_rdy, 0);

        // R4: overrun replaces held character
        for (int i = 0; i < 16; i++) send(8'(8'h60 + i), 3'b000, 1);
        send(8'h7A, 3'b000, 1);
        send(8'h7B, 3'b000, 2);
        chk("R4 overrun flag set", st_ovr, 1);
        chk("R4 store still full", st_full, 1);
        for (int i = 0; i < 17; i++) cpu_read();
        chk("R4 drained", st_rdy, 0);
        chk("R4 overrun sticky", st_ovr, 1);
        tick(); err_rst_cmd = 1; tick(); err_rst_cmd = 0;
        chk("R5 error reset clears overrun", st_ovr, 0);

        // R5: block mode accumulation
        blk_mode = 1'b1;
        send(8'h81, 3'b001, 1);
        send(8'h82, 3'b000, 1);
        send(8'h83, 3'b010, 1);
        chk("R5 accumulated flags", {st_brk, st_ferr, st_perr}, 3'b011);
        repeat (3) cpu_read();
        chk("R5 flags kept after reads", {st_brk, st_ferr, st_perr}, 3'b011);
        tick(); err_rst_cmd = 1; tick(); err_rst_cmd = 0;
        chk("R5 error reset clears flags", {st_brk, st_ferr, st_perr}, 3'b000);
        blk_mode = 1'b0;

        // R9: disable keeps stored data, ignores new
        send(8'h91, 3'b000, 1);
        send(8'h92, 3'b000, 1);
        tick(); rx_dis_cmd = 1; tick(); rx_dis_cmd = 0;
        send(8'h93, 3'b000, 0);
        chk("R9 stored chars readable", st_rdy, 1);
        repeat (2) cpu_read();
        chk("R9 new char ignored", st_rdy, 0);
        tick(); rx_en_cmd = 1; tick(); rx_en_cmd = 0;
        for (int i = 0; i < 16; i++) send(8'(8'hA0 + i), 3'b000, 1);
        send(8'hEE, 3'b000, 0);
        tick(); rx_dis_cmd = 1; tick(); rx_dis_cmd = 0;
        tick(); rx_en_cmd = 1; tick(); rx_en_cmd = 0;
        for (int i = 0; i < 16; i++) cpu_read();
        chk("R9 held char lost on disable", st_rdy, 0);
        tick();
        chk("R8 rts back after drain", rts, 1);

        // R10: receiver reset
        blk_mode = 1'b1;
        send(8'hB1, 3'b101, 0);
        chk("R5 block flags before reset", {st_brk, st_ferr, st_perr}, 3'b101);
        tick(); rx_rst_cmd = 1; tick(); rx_rst_cmd = 0;
        chk("R10 store empty", st_rdy, 0);
        chk("R10 rts cleared", rts, 0);
        chk("R10 flags cleared", {st_brk, st_ferr, st_perr}, 3'b000);
        blk_mode = 1'b0;
        send(8'hB2, 3'b000, 0);
        chk("R10 receiver left disabled", st_rdy, 0);
        tick(); rx_en_cmd = 1; tick(); rx_en_cmd = 0;
        for (int i = 0; i < 16; i++) send(8'(8'hC0 + i), 3'b000, 1);
        send(8'hD0, 3'b000, 1);
        chk("R10 auto rts disarmed", rts, 0);
        for (int i = 0; i < 17; i++) cpu_read();
        tick();
        chk("R10 rts stays low until command", rts, 0);
        chk("R1 all read", st_rdy, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule